// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O peripheral. It serves a parameterised number of 32-pin register groups. Each pin has a direction bit, an output latch and a synchronised view of the pad level. The output latch can be loaded whole, or changed atomically by writing a mask to a set word or a clear word. Pad levels pass through a two-flop synchroniser before software can read them or the edge logic can see them.

Every pin can flag a rising edge, a falling edge or both. Each edge kind is switched on and off through its own pair of set and clear mask words. A flagged edge latches a sticky status bit, and software clears that bit by writing 1 to it. Pins are grouped into 16-pin interrupt banks, so each 32-pin group feeds two banks. Each bank drives one registered level interrupt, which is gated by that bank's bit in a global enable word.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Reset conditions. After a synchronous reset, every direction bit is 1, so all pins are inputs and `pin_oe` is 0. The output latch, the edge enables, the status bits, the bank enables, `irq` and `bus_rdata` are all 0.
- R2: The direction word is word 0 of a group. A direction bit of 1 makes the pin an input and a bit of 0 makes it an output, so `pin_oe[i]` is the inverse of direction bit i. Reading word 0 returns the direction bits.
- R3: The output latch drives `pin_out` directly. Writing word 1 loads the whole latch. Writing a mask to word 2 sets the latch bits where the mask is 1. Writing a mask to word 3 clears the latch bits where the mask is 1. Bits written as 0 keep their value. Reads of words 1, 2 and 3 return the latch.
- R4: Word 4 returns the pad level of each pin, in either direction, as seen through the two-flop synchroniser. Writes to word 4 have no effect.
- R5: Rising-edge enables are set by word 5 and cleared by word 6. Falling-edge enables are set by word 7 and cleared by word 8. In each case only the bits written as 1 change. Reads of words 5 and 6 return the rising enables, and reads of words 7 and 8 return the falling enables.
- R6: An enabled edge on a pin sets that pin's status bit in word 9. The bit is set at the third clock edge after the pad changes. Edges on pins whose enables are off leave the status unchanged.
- R7: Writing 1 to a bit of word 9 clears it, and bits written as 0 are kept. If an enabled edge arrives in the same cycle as the clear, the edge wins and the bit stays 1.
- R8: Interrupt bank 2k covers bits 15:0 of group k, and bank 2k+1 covers bits 31:16 of group k. The word at byte offset 0x8 holds the bank enables, with bit n enabling bank n. `irq[n]` is registered and goes high one cycle after any status bit of bank n is 1 while bank n is enabled.
- R9: Address map. Group k starts at byte offset 0x10 + k*0x28, and word w of the group is at that start + 4*w. Any other address reads as 0, and writes to it change no register.
- R10: Bus reads are registered. `bus_rdata` shows, one cycle later, the value the addressed word held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the accessed word |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_SETS*32 | Pad levels |
| pin_out | output | NUM_SETS*32 | Output latch |
| pin_oe | output | NUM_SETS*32 | Output enable, 1 = driven |
| irq | output | NUM_SETS*2 | Per-bank level interrupts |

## Verification
The bench builds the block with its defaults: two 32-pin groups, 16-pin banks and an 8-bit address. That gives four interrupt banks, so both halves of both groups are exercised, and the group stride places an unused address directly above the second group. Random operations on set and clear masks, edge enables, single-pin toggles, status clears and bank enables run against a bench-side model. Directed cases cover the reset state, synchroniser latency, the edge-versus-clear collision and unmapped addresses.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int GRP_W        = 32;
  localparam int GRP_WORDS    = 10;
  localparam int GRP_BASE     = 16;
  localparam int GRP_STRIDE   = 40;
  localparam int BANK_EN_ADDR = 8;

  typedef enum logic [3:0] {
    W_DIR      = 4'd0,
    W_OUT      = 4'd1,
    W_OUT_SET  = 4'd2,
    W_OUT_CLR  = 4'd3,
    W_PAD      = 4'd4,
    W_RISE_SET = 4'd5,
    W_RISE_CLR = 4'd6,
    W_FALL_SET = 4'd7,
    W_FALL_CLR = 4'd8,
    W_STATUS   = 4'd9
  } word_e;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_edge_pkg::*;
#(
  parameter int NUM_SETS = 2,
  parameter int ADDR_W   = 8
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_SETS-1:0] grp_hit,
  output word_e               word,
  output logic                en_hit
);
  always_comb begin
    int unsigned a;
    a       = 32'(addr);
    grp_hit = '0;
    word    = W_DIR;
    en_hit  = (a == BANK_EN_ADDR);
    for (int k = 0; k < NUM_SETS; k++) begin
      int unsigned lo;
      lo = GRP_BASE + k * GRP_STRIDE;
      if (a >= lo && a < lo + GRP_WORDS * 4 && addr[1:0] == 2'b00) begin
        grp_hit[k] = 1'b1;
        word       = word_e'(4'((a - lo) >> 2));
      end
    end
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_regset.sv
module gpio_regset
  import gpio_edge_pkg::*;
#(
  parameter int BANK_W = 16,
  localparam int NB    = GRP_W / BANK_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             we,
  input  word_e            word,
  input  logic [31:0]      wdata,
  input  logic [GRP_W-1:0] pad_sync,
  output logic [31:0]      rdata,
  output logic [GRP_W-1:0] dir_q,
  output logic [GRP_W-1:0] out_q,
  output logic [NB-1:0]    bank_pend
);
  logic [GRP_W-1:0] rise_q, fall_q, stat_q, prev_q;
  logic [GRP_W-1:0] edges, clr_mask;
  logic             wr;

  assign wr       = sel & we;
  assign edges    = (pad_sync & ~prev_q & rise_q) | (~pad_sync & prev_q & fall_q);
  assign clr_mask = (wr && word == W_STATUS) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '1;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= pad_sync;
      stat_q <= (stat_q & ~clr_mask) | edges;
      if (wr) begin
        case (word)
          W_DIR:      dir_q  <= wdata;
          W_OUT:      out_q  <= wdata;
          W_OUT_SET:  out_q  <= out_q | wdata;
          W_OUT_CLR:  out_q  <= out_q & ~wdata;
          W_RISE_SET: rise_q <= rise_q | wdata;
          W_RISE_CLR: rise_q <= rise_q & ~wdata;
          W_FALL_SET: fall_q <= fall_q | wdata;
          W_FALL_CLR: fall_q <= fall_q & ~wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (word)
      W_DIR:                          rdata = dir_q;
      W_OUT, W_OUT_SET, W_OUT_CLR:    rdata = out_q;
      W_PAD:                          rdata = pad_sync;
      W_RISE_SET, W_RISE_CLR:         rdata = rise_q;
      W_FALL_SET, W_FALL_CLR:         rdata = fall_q;
      W_STATUS:                       rdata = stat_q;
      default:                        rdata = '0;
    endcase
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign bank_pend[b] = |stat_q[b*BANK_W +: BANK_W];
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NUM_SETS = 2,
  parameter int ADDR_W   = 8,
  parameter int BANK_W   = 16,
  localparam int NPINS   = NUM_SETS * GRP_W,
  localparam int NBANKS  = NPINS / BANK_W,
  localparam int BPS     = GRP_W / BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NBANKS-1:0] irq
);
  logic [NUM_SETS-1:0] grp_hit;
  word_e               word;
  logic                en_hit;
  logic [NPINS-1:0]    pad_sync, dir_all;
  logic [NBANKS-1:0]   pend, bank_en_q;
  logic [31:0]         grp_rd [NUM_SETS];
  logic [31:0]         rd_n;

  gpio_addr_dec #(.NUM_SETS(NUM_SETS), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .grp_hit(grp_hit), .word(word), .en_hit(en_hit)
  );

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pad_sync)
  );

  for (genvar k = 0; k < NUM_SETS; k++) begin : g_grp
    gpio_regset #(.BANK_W(BANK_W)) u_set (
      .clk(clk), .rst(rst), .sel(grp_hit[k]), .we(bus_we), .word(word),
      .wdata(bus_wdata), .pad_sync(pad_sync[k*GRP_W +: GRP_W]),
      .rdata(grp_rd[k]), .dir_q(dir_all[k*GRP_W +: GRP_W]),
      .out_q(pin_out[k*GRP_W +: GRP_W]), .bank_pend(pend[k*BPS +: BPS])
    );
  end

  assign pin_oe = ~dir_all;

  always_comb begin
    rd_n = en_hit ? 32'(bank_en_q) : '0;
    for (int k = 0; k < NUM_SETS; k++)
      if (grp_hit[k]) rd_n = grp_rd[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_en_q <= '0;
      bus_rdata <= '0;
      irq       <= '0;
    end else begin
      if (bus_we && en_hit) bank_en_q <= bus_wdata[NBANKS-1:0];
      bus_rdata <= rd_n;
      irq       <= pend & bank_en_q;
    end
  end
endmodule

// File: rtl/gpio_edge_chk.sv
module gpio_edge_chk #(
  parameter int NPINS  = 64,
  parameter int NBANKS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic [NBANKS-1:0] irq,
  input logic [NBANKS-1:0] bank_en
);
  assert_oe_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> $stable(pin_oe));

  assert_out_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> $stable(pin_out));

  assert_irq_off_R8: assert property (@(posedge clk) disable iff (rst)
    (bank_en == '0) |=> (irq == '0));

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (rst)
    ((irq & ~$past(bank_en)) == '0));
endmodule

bind gpio_edge_ctrl gpio_edge_chk #(.NPINS(NPINS), .NBANKS(NBANKS)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .pin_out(pin_out),
  .pin_oe(pin_oe), .irq(irq), .bank_en(bank_en_q)
);

// File: tb/sim_gpio_edge_ctrl.sv
module sim_gpio_edge_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 2;
  localparam int NP = NS * 32;
  localparam int NB = NP / 16;

  logic          clk = 0, rst = 1, bus_we = 0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0, bus_rdata;
  logic [NP-1:0] pins = '0, pin_out, pin_oe;
  logic [NB-1:0] irq;

  logic [NP-1:0] m_out, m_dir, m_rise, m_fall, m_stat;
  logic [NB-1:0] m_en;
  int total = 0, bad = 0;
  bit done = 0;

  gpio_edge_ctrl u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pins),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] ra(int k, int w);
    return 8'(16 + k * 40 + w * 4);
  endfunction

  function automatic logic [NB-1:0] exp_irq();
    logic [NB-1:0] r;
    for (int b = 0; b < NB; b++) r[b] = (|m_stat[b*16 +: 16]) & m_en[b];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 0;
    @(posedge clk); #1; d = bus_rdata;
  endtask

  task automatic toggle(input int i);
    @(negedge clk);
    pins[i] = ~pins[i];
    if (pins[i] && m_rise[i]) m_stat[i] = 1'b1;
    if (!pins[i] && m_fall[i]) m_stat[i] = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    m_out = '0; m_dir = '1; m_rise = '0; m_fall = '0; m_stat = '0; m_en = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #1;
    chk(pin_oe == '0 && pin_out == '0 && irq == '0, "R1 reset pins", {pin_oe[31:0], pin_out[31:0]}, 0);
    chk(bus_rdata == '0, "R1 reset rdata", bus_rdata, 0);
    rd(ra(1, 0), d); chk(d == 32'hffff_ffff, "R1 reset dir", d, 32'hffff_ffff);
    rd(ra(0, 9), d); chk(d == 0, "R1 reset status", d, 0);

    // R2 direction
    wr(ra(1, 0), 32'h0000_f0f0); m_dir[63:32] = 32'h0000_f0f0;
    #1 chk(pin_oe == ~m_dir, "R2 oe", pin_oe, ~m_dir);
    rd(ra(1, 0), d); chk(d == 32'h0000_f0f0, "R2 dir read", d, 32'h0000_f0f0);

    // R3 output latch
    wr(ra(0, 1), 32'h1234_5678); m_out[31:0] = 32'h1234_5678;
    wr(ra(0, 2), 32'h8000_0001); m_out[31:0] |= 32'h8000_0001;
    wr(ra(0, 3), 32'h0000_0070); m_out[31:0] &= ~32'h0000_0070;
    #1 chk(pin_out == m_out, "R3 latch", pin_out, m_out);
    rd(ra(0, 3), d); chk(d == m_out[31:0], "R3 read clr word", d, m_out[31:0]);

    // R4 pad readback and latency, write ignored
    @(negedge clk); pins[63:32] = 32'hdead_beef;
    @(posedge clk); #1;
    rd(ra(1, 4), d); chk(d == 32'h0, "R4 sync latency", d, 0);
    repeat (2) @(negedge clk);
    rd(ra(1, 4), d); chk(d == 32'hdead_beef, "R4 pad", d, 32'hdead_beef);
    wr(ra(1, 4), 32'h0);
    rd(ra(1, 4), d); chk(d == 32'hdead_beef, "R4 write ignored", d, 32'hdead_beef);
    @(negedge clk); pins = '0;
    repeat (4) @(negedge clk);

    // R5/R6/R7 directed: pin 0 both edges, collision
    wr(ra(0, 5), 32'h1); wr(ra(0, 7), 32'h1);
    m_rise[0] = 1; m_fall[0] = 1;
    rd(ra(0, 6), d); chk(d == 32'h1, "R5 rise read", d, 1);
    wr(ra(0, 2), 0);
    toggle(0);
    rd(ra(0, 9), d); chk(d == 32'h1, "R6 rise edge", d, 1);
    @(negedge clk); pins[0] = 0;
    @(negedge clk); @(negedge clk);
    bus_addr = ra(0, 9); bus_we = 1; bus_wdata = 32'h1;
    @(negedge clk); bus_we = 0;
    rd(ra(0, 9), d); chk(d == 32'h1, "R7 edge wins over clear", d, 1);
    wr(ra(0, 9), 32'h1); m_stat[0] = 0;
    rd(ra(0, 9), d); chk(d == 32'h0, "R7 w1c", d, 0);
    wr(ra(0, 6), 32'h1); m_rise[0] = 0;
    toggle(0);
    rd(ra(0, 9), d); chk(d == 32'h0, "R6 disabled edge ignored", d, 0);
    toggle(0); m_stat[0] = 1;
    rd(ra(0, 9), d); chk(d == 32'h1, "R6 fall edge", d, 1);

    // R8 bank irq
    repeat (2) @(negedge clk); #1;
    chk(irq == '0, "R8 irq off when disabled", irq, 0);
    wr(8'h08, 32'hf); m_en = 4'hf;
    @(negedge clk); #1;
    chk(irq == 4'b0001, "R8 bank0 irq", irq, 4'b0001);
    rd(8'h08, d); chk(d == 32'hf, "R8 enable read", d, 32'hf);

    // R9 unmapped
    rd(8'h04, d); chk(d == 0, "R9 unmapped read", d, 0);
    rd(8'h60, d); chk(d == 0, "R9 above last group", d, 0);
    wr(8'h60, 32'hffff_ffff); wr(8'h0c, 32'hffff_ffff);
    #1 chk(pin_out == m_out && pin_oe == ~m_dir, "R9 unmapped write", pin_out, m_out);

    // random phase
    for (int it = 0; it < 300; it++) begin
      int k, op, i;
      logic [31:0] r;
      k = int'($urandom_range(0, NS - 1));
      op = int'($urandom_range(0, 6));
      r = $urandom;
      case (op)
        0: begin wr(ra(k, 2), r); m_out[k*32 +: 32] |= r; end
        1: begin wr(ra(k, 3), r); m_out[k*32 +: 32] &= ~r; end
        2: begin wr(ra(k, 5), r); m_rise[k*32 +: 32] |= r; end
        3: begin wr(ra(k, 8), r); m_fall[k*32 +: 32] &= ~r; end
        4: begin i = int'($urandom_range(0, NP - 1)); toggle(i); end
        5: begin wr(ra(k, 9), r); m_stat[k*32 +: 32] &= ~r; end
        default: begin wr(8'h08, r); m_en = r[NB-1:0]; end
      endcase
      if (op == 3 && r[0]) begin wr(ra(k, 7), r ^ 32'h5); m_fall[k*32 +: 32] |= r ^ 32'h5; end
      @(negedge clk); #1;
      chk(pin_out == m_out, "R3 random latch", pin_out, m_out);
      chk(irq == exp_irq(), "R8 random irq", irq, exp_irq());
      if (it % 4 == 0) begin
        rd(ra(k, 9), d); chk(d == m_stat[k*32 +: 32], "R6 R7 random status", d, m_stat[k*32 +: 32]);
        rd(ra(k, 6), d); chk(d == m_rise[k*32 +: 32], "R5 random rise", d, m_rise[k*32 +: 32]);
        rd(ra(k, 8), d); chk(d == m_fall[k*32 +: 32], "R5 random fall", d, m_fall[k*32 +: 32]);
        rd(ra(k, 1), d); chk(d == m_out[k*32 +: 32], "R10 read latch", d, m_out[k*32 +: 32]);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule